// File: doc/BRIEF.md
# Banked Internal Scratch Memory

This block is the 256-byte on-chip data store of an 8-bit microcontroller core. A single memory array is reached in four ways: as a working register R0 to R7 in one of four register banks, as a byte by direct address, as a byte by indirect (pointer) address, and as a single bit within a fixed bit-addressable window. The core presents one access per cycle with an access code, an address, a write strobe and write data. The block returns the byte, the selected bit, and a flag when the access falls into special-function-register space.

The upper half of the address range is ambiguous by design. A direct access there belongs to the special function registers, which live outside this block, so the block raises a select flag, passes the address on and leaves its own storage alone. An indirect access to the same address reaches the RAM byte. The register-bank choice comes from two status bits. The block samples them on each clock edge, so a bank change made by the core applies from the following cycle.

Top module: `core_data_ram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the bank register is 0, so register access with index n reaches byte n.
- R2: Reset does not clear or change stored bytes; a byte written before reset reads back unchanged after it.
- R3: With `acc_kind` = 0 (register), byte `bank*8 + addr[2:0]` is accessed, where bank is the `bank_sel` value sampled at the previous rising clock edge; `addr[7:3]` are ignored.
- R4: With `acc_kind` = 1 (direct) and `addr` below 0x80, the RAM byte at `addr` is read and written, and `sfr_sel` is low.
- R5: With `acc_kind` = 1 and `addr` at 0x80 or above, `sfr_sel` is high, `sfr_addr` equals `addr`, `rd_data` is 0 and a write leaves every RAM byte unchanged.
- R6: With `acc_kind` = 2 (indirect), any of the 256 bytes is read and written at `addr`, `sfr_sel` is low even for 0x80 to 0xFF.
- R7: With `acc_kind` = 3 (bit) and `addr` below 0x80, `bit_val` is bit `addr[2:0]` of byte `0x20 + addr[6:3]`, and `rd_data` is that whole byte.
- R8: A bit write stores `wr_data[0]` into the selected bit in one clock and leaves the other seven bits of the byte unchanged.
- R9: With `acc_kind` = 3 and `addr` at 0x80 or above, `sfr_sel` is high, `sfr_addr` is `addr` with its low three bits cleared, `bit_val` is 0 and no RAM byte changes.
- R10: Reads are combinational from the stored array; a write with `wr_en` high takes effect at the rising edge, so the same cycle shows the old value and the next cycle the new one.
- R11: When `sfr_sel` is low, `sfr_addr` is 0; outside bit mode `bit_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the bank register |
| acc_kind | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| addr | input | 8 | Byte address, bit address or register index |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Byte to write; bit 0 used for bit writes |
| bank_sel | input | 2 | Register-bank select bits from the status word |
| rd_data | output | 8 | Byte read from RAM, 0 on special-register accesses |
| sfr_sel | output | 1 | Access targets special-function-register space |
| sfr_addr | output | 8 | Special-register byte address when `sfr_sel` is high |
| bit_val | output | 1 | Selected bit for bit-mode RAM accesses |

## Verification
The bench writes distinct markers at the edges of the regions, 0x1F, 0x20, 0x2F and 0x30, so that a decoder off by one byte reads a neighbour's marker instead of its own. It writes by direct address at 0x80 and 0xFF and then reads the same bytes indirectly; a design that let direct writes fall through to RAM, or that sent indirect reads to register space, returns the wrong marker or a zero. Bank switching is checked in the cycle the select changes and the cycle after, which catches a bank taken straight from the input, and a bit write at 0x83 is followed by a read of 0x30 to catch a bit address that wraps into RAM instead of being flagged. Clearing one bit then re-reading the whole byte exposes a write that overwrites the other seven bits.

// File: rtl/idm_pkg.sv
package idm_pkg;
   typedef enum logic [1:0] {
      ACC_REG      = 2'd0,
      ACC_DIRECT   = 2'd1,
      ACC_INDIRECT = 2'd2,
      ACC_BIT      = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/idm_bank_reg.sv
module idm_bank_reg #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_sel_i,
   output logic [BANK_W-1:0] bank_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_o <= '0;
      else        bank_o <= bank_sel_i;
   end

   // R1: reset forces bank zero
   a_r1_bank_reset: assert property (@(posedge clk) !rst_n |=> bank_o == '0);
   // R3: bank follows the select bits one edge later
   a_r3_bank_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> bank_o == $past(bank_sel_i));
endmodule

// File: rtl/idm_decode.sv
module idm_decode
   import idm_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int BANK_W        = 2,
   parameter int REG_W         = 3,
   parameter int BIT_BASE      = 32,
   parameter int BIT_BYTES     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [ADDR_W-1:0] ram_idx_o,
   output logic              ram_we_o,
   output logic [DATA_W-1:0] wmask_o,
   output logic [DATA_W-1:0] wval_o,
   output logic              sfr_sel_o,
   output logic [ADDR_W-1:0] sfr_addr_o,
   output logic              bit_mode_o,
   output logic [$clog2(DATA_W)-1:0] bit_pos_o
);
   localparam int BITPOS_W = $clog2(DATA_W);
   localparam int MSB      = ADDR_W - 1;

   logic ram_hit;

   always_comb begin
      ram_idx_o  = '0;
      ram_hit    = 1'b0;
      wmask_o    = '1;
      wval_o     = wr_data_i;
      sfr_sel_o  = 1'b0;
      sfr_addr_o = '0;
      bit_mode_o = 1'b0;
      bit_pos_o  = '0;
      unique case (kind_i)
         ACC_REG: begin
            ram_idx_o = ADDR_W'({bank_i, addr_i[REG_W-1:0]});
            ram_hit   = 1'b1;
         end
         ACC_DIRECT: begin
            if (addr_i[MSB]) begin
               sfr_sel_o  = 1'b1;
               sfr_addr_o = addr_i;
            end else begin
               ram_idx_o = addr_i;
               ram_hit   = 1'b1;
            end
         end
         ACC_INDIRECT: begin
            ram_idx_o = addr_i;
            ram_hit   = 1'b1;
         end
         ACC_BIT: begin
            bit_mode_o = 1'b1;
            if (addr_i[MSB]) begin
               sfr_sel_o  = 1'b1;
               sfr_addr_o = {addr_i[MSB:BITPOS_W], {BITPOS_W{1'b0}}};
            end else begin
               bit_pos_o = addr_i[BITPOS_W-1:0];
               ram_idx_o = ADDR_W'(BIT_BASE) + ADDR_W'(addr_i[MSB-1:BITPOS_W]);
               ram_hit   = 1'b1;
               wmask_o   = DATA_W'(1) << addr_i[BITPOS_W-1:0];
               wval_o    = {DATA_W{wr_data_i[0]}};
            end
         end
         default: ;
      endcase
   end

   assign ram_we_o = wr_en_i & ram_hit;

   // R3: register operands stay inside the active bank
   a_r3_reg_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_REG) |-> (ram_idx_o >> REG_W) == ADDR_W'(bank_i) && !sfr_sel_o);
   // R7: RAM bit accesses land in the bit window with a single-bit mask
   a_r7_bit_window: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_BIT && !addr_i[MSB]) |->
         (int'(ram_idx_o) >= BIT_BASE) && (int'(ram_idx_o) < BIT_BASE + BIT_BYTES)
         && $countones(wmask_o) == 1);
   // R6: indirect never selects special-register space
   a_r6_indirect_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_INDIRECT) |-> !sfr_sel_o && ram_idx_o == addr_i);
endmodule

// File: rtl/idm_store.sv
module idm_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] idx_i,
   input  logic [DATA_W-1:0] wmask_i,
   input  logic [DATA_W-1:0] wval_i,
   output logic [DATA_W-1:0] rd_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH*DATA_W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we_i && idx_i == ADDR_W'(g))
            cell_q <= (cell_q & ~wmask_i) | (wval_i & wmask_i);
      end
      assign flat[g*DATA_W +: DATA_W] = cell_q;
   end

   assign rd_o = flat[idx_i*DATA_W +: DATA_W];
endmodule

// File: rtl/core_data_ram.sv
module core_data_ram
   import idm_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int NUM_BANKS     = 4,
   parameter int REGS_PER_BANK = 8,
   parameter int BIT_BASE      = 32,
   parameter int BIT_BYTES     = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   acc_kind,
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         sfr_sel,
   output logic [ADDR_W-1:0]            sfr_addr,
   output logic                         bit_val
);
   localparam int BANK_W   = $clog2(NUM_BANKS);
   localparam int REG_W    = $clog2(REGS_PER_BANK);
   localparam int BITPOS_W = $clog2(DATA_W);
   localparam int HALF     = 1 << (ADDR_W - 1);

   if (NUM_BANKS * REGS_PER_BANK > BIT_BASE)
      $error("register banks overlap the bit window");
   if (BIT_BYTES * DATA_W != HALF)
      $error("bit window must cover exactly the lower-half bit addresses");
   if (BIT_BASE + BIT_BYTES > HALF)
      $error("bit window must lie in the lower half");
   if ((1 << BITPOS_W) != DATA_W || (1 << REG_W) != REGS_PER_BANK)
      $error("data width and bank size must be powers of two");

   logic [BANK_W-1:0]   bank_q;
   logic [ADDR_W-1:0]   ram_idx;
   logic                ram_we;
   logic [DATA_W-1:0]   wmask, wval, store_rd;
   logic                bit_mode;
   logic [BITPOS_W-1:0] bit_pos;

   idm_bank_reg #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .bank_sel_i(bank_sel), .bank_o(bank_q));

   idm_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .REG_W(REG_W),
      .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .kind_i(acc_kind_e'(acc_kind)), .addr_i(addr),
      .bank_i(bank_q), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .ram_idx_o(ram_idx), .ram_we_o(ram_we), .wmask_o(wmask), .wval_o(wval),
      .sfr_sel_o(sfr_sel), .sfr_addr_o(sfr_addr), .bit_mode_o(bit_mode),
      .bit_pos_o(bit_pos));

   idm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we_i(ram_we), .idx_i(ram_idx), .wmask_i(wmask),
      .wval_i(wval), .rd_o(store_rd));

   assign rd_data = sfr_sel ? '0 : store_rd;
   assign bit_val = bit_mode && !sfr_sel && store_rd[bit_pos];

   // R5 / R9: a special-register access never writes RAM
   a_r5_sfr_no_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel |-> !ram_we && rd_data == '0 && !bit_val);
   // R11: address output idle unless flagged
   a_r11_sfr_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sfr_sel |-> sfr_addr == '0);
endmodule

// File: tb/core_data_ram_test.sv
module core_data_ram_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] acc_kind = 2'd2;
   logic [7:0] addr = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] bank_sel = 2'd0;
   logic [7:0] rd_data;
   logic       sfr_sel;
   logic [7:0] sfr_addr;
   logic       bit_val;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   core_data_ram uut (
      .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .bank_sel(bank_sel),
      .rd_data(rd_data), .sfr_sel(sfr_sel), .sfr_addr(sfr_addr), .bit_val(bit_val));

   localparam logic [1:0] K_REG = 2'd0, K_DIR = 2'd1, K_IND = 2'd2, K_BIT = 2'd3;

   // {bank, kind, addr, wr, wdata, exp_rd, exp_sfr, exp_sfr_addr, exp_bit}
   localparam int NV = 32;
   localparam logic [38:0] VEC [NV] = '{
      {2'd0, K_IND, 8'h00, 1'b1, 8'h11, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h07, 1'b1, 8'h17, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h1F, 1'b1, 8'h3F, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h20, 1'b1, 8'h81, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h2F, 1'b1, 8'h7E, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h30, 1'b1, 8'hC3, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h80, 1'b1, 8'h5A, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'hFF, 1'b1, 8'hA5, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h18, 1'b1, 8'h99, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_REG, 8'h00, 1'b0, 8'h00, 8'h11, 1'b0, 8'h00, 1'b0},
      {2'd0, K_REG, 8'h07, 1'b0, 8'h00, 8'h17, 1'b0, 8'h00, 1'b0},
      {2'd3, K_REG, 8'h00, 1'b0, 8'h00, 8'h11, 1'b0, 8'h00, 1'b0},
      {2'd3, K_REG, 8'h00, 1'b0, 8'h00, 8'h99, 1'b0, 8'h00, 1'b0},
      {2'd3, K_REG, 8'h07, 1'b0, 8'h00, 8'h3F, 1'b0, 8'h00, 1'b0},
      {2'd3, K_REG, 8'h05, 1'b1, 8'h44, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd3, K_DIR, 8'h1D, 1'b0, 8'h00, 8'h44, 1'b0, 8'h00, 1'b0},
      {2'd0, K_DIR, 8'h80, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80, 1'b0},
      {2'd0, K_DIR, 8'hFF, 1'b1, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b0},
      {2'd0, K_IND, 8'hFF, 1'b0, 8'h00, 8'hA5, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h80, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 1'b0},
      {2'd0, K_BIT, 8'h00, 1'b0, 8'h00, 8'h81, 1'b0, 8'h00, 1'b1},
      {2'd0, K_BIT, 8'h07, 1'b0, 8'h00, 8'h81, 1'b0, 8'h00, 1'b1},
      {2'd0, K_BIT, 8'h01, 1'b0, 8'h00, 8'h81, 1'b0, 8'h00, 1'b0},
      {2'd0, K_BIT, 8'h7F, 1'b0, 8'h00, 8'h7E, 1'b0, 8'h00, 1'b0},
      {2'd0, K_BIT, 8'h7E, 1'b0, 8'h00, 8'h7E, 1'b0, 8'h00, 1'b1},
      {2'd0, K_BIT, 8'h7F, 1'b1, 8'h01, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h2F, 1'b0, 8'h00, 8'hFE, 1'b0, 8'h00, 1'b0},
      {2'd0, K_BIT, 8'h00, 1'b1, 8'hFE, 8'h00, 1'b0, 8'h00, 1'b0},
      {2'd0, K_DIR, 8'h20, 1'b0, 8'h00, 8'h80, 1'b0, 8'h00, 1'b0},
      {2'd0, K_BIT, 8'h83, 1'b1, 8'h01, 8'h00, 1'b1, 8'h80, 1'b0},
      {2'd0, K_IND, 8'h30, 1'b0, 8'h00, 8'hC3, 1'b0, 8'h00, 1'b0},
      {2'd0, K_IND, 8'h1F, 1'b0, 8'h00, 8'h3F, 1'b0, 8'h00, 1'b0}
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [1:0] b, input logic [1:0] k, input logic [7:0] a,
                        input logic w, input logic [7:0] d);
      @(negedge clk);
      bank_sel = b; acc_kind = k; addr = a; wr_en = w; wr_data = d;
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state: flag path works, RAM read data suppressed (R5, R11)
      drive(2'd0, K_DIR, 8'h90, 1'b0, 8'h00);
      check("R5 sfr_sel in reset", {7'd0, sfr_sel}, 8'h01);
      check("R5 rd_data zero", rd_data, 8'h00);
      drive(2'd0, K_IND, 8'h10, 1'b0, 8'h00);
      check("R11 sfr_addr idle", sfr_addr, 8'h00);
      check("R11 bit_val idle", {7'd0, bit_val}, 8'h00);
      @(negedge clk) rst_n = 1'b1;

      // vector table: R3 R4 R5 R6 R7 R8 R9 and boundary bytes
      for (int i = 0; i < NV; i++) begin
         logic [38:0] v;
         v = VEC[i];
         drive(v[38:37], v[36:35], v[34:27], v[26], v[25:18]);
         if (!v[26]) begin
            check($sformatf("R3/R4/R6/R7 rd vec %0d", i), rd_data, v[17:10]);
            check($sformatf("R7 bit vec %0d", i), {7'd0, bit_val}, {7'd0, v[0]});
         end
         check($sformatf("R5/R9 sfr_sel vec %0d", i), {7'd0, sfr_sel}, {7'd0, v[9]});
         check($sformatf("R9/R11 sfr_addr vec %0d", i), sfr_addr, v[8:1]);
      end

      // R10: same-cycle old value, next-cycle new value
      drive(2'd0, K_IND, 8'h40, 1'b1, 8'h3C);
      drive(2'd0, K_IND, 8'h40, 1'b1, 8'h77);
      check("R10 old value before edge", rd_data, 8'h3C);
      drive(2'd0, K_IND, 8'h40, 1'b0, 8'h00);
      check("R10 new value after edge", rd_data, 8'h77);

      // R3: banks 1 and 2, upper index bits ignored
      drive(2'd0, K_IND, 8'h08, 1'b1, 8'h21);
      drive(2'd0, K_IND, 8'h10, 1'b1, 8'h22);
      drive(2'd1, K_REG, 8'h00, 1'b0, 8'h00);
      drive(2'd1, K_REG, 8'hF8, 1'b0, 8'h00);
      check("R3 bank1 R0 upper bits ignored", rd_data, 8'h21);
      drive(2'd2, K_REG, 8'h00, 1'b0, 8'h00);
      drive(2'd2, K_REG, 8'h00, 1'b0, 8'h00);
      check("R3 bank2 R0", rd_data, 8'h22);

      // R1 / R2: reset returns to bank 0, keeps contents
      @(negedge clk) rst_n = 1'b0;
      drive(2'd2, K_REG, 8'h00, 1'b0, 8'h00);
      check("R1 bank 0 in reset", rd_data, 8'h11);
      drive(2'd2, K_IND, 8'h40, 1'b0, 8'h00);
      check("R2 byte kept through reset", rd_data, 8'h77);
      drive(2'd2, K_IND, 8'h2F, 1'b0, 8'h00);
      check("R2 bit byte kept through reset", rd_data, 8'hFE);
      drive(2'd2, K_REG, 8'h00, 1'b0, 8'h00);
      rst_n = 1'b1;
      check("R1 bank 0 first cycle after reset", rd_data, 8'h11);
      drive(2'd2, K_REG, 8'h00, 1'b0, 8'h00);
      check("R3 bank2 after reset", rd_data, 8'h22);
      drive(2'd2, K_IND, 8'h00, 1'b0, 8'h00);
      check("R9 bit at 0x83 left byte 0x00", rd_data, 8'h11);

      finish_run();
   end
endmodule